// File: doc/BRIEF.md
# Differential Bi-Phase Bit Decoder

This block turns a demodulated wireless-charging data line into a stream of bits. The line carries differential bi-phase coding at a nominal 2 kbit/s. Each bit period starts with a transition. A logic 1 adds a second transition halfway through the period. The decoder brings the line into the clock domain and counts clock cycles between successive transitions. It sorts every interval by comparing it against a window around the nominal bit period.

One interval that fits the window gives a 0. Two consecutive intervals whose sum fits the window give a 1. After a long quiet stretch, the first half-bit of a 1 can be caught on its own when the line has just fallen. An interval that is longer than the window and decides no bit raises an abort strobe, so that byte framing downstream can return to idle. Byte assembly, parity and packet handling belong to the next stage.

The nominal period in clock cycles is `CLK_HZ / BIT_RATE`. The window limits are integer cycle counts fixed at elaboration.

Top module: `bphase_bit_decoder`

## Requirements
- R1: With the period P = CLK_HZ/BIT_RATE, an interval L counts as in the window only when 4·L > 3·P and 4·L < 5·P, with both limits excluded. For P = 40, that is L from 31 to 49.
- R2: When a stored interval exists and the stored interval plus the current interval is in the window, the decoder emits a 1 (bitValid high, bitValue = 1). This rule has priority over all the others.
- R3: Otherwise, when the current interval alone is in the window, the decoder emits a 0 (bitValid high, bitValue = 0).
- R4: Otherwise, the decoder emits a 1 when all of the following hold:
  - a stored interval exists;
  - the edge just seen was falling (line now 0);
  - twice the current interval is in the window;
  - the stored interval satisfies 4·L > 5·P.
- R5: When no bit is decided and the current interval satisfies 4·L > 5·P, abortStb pulses for one cycle. The abort interval is still kept as the stored interval.
- R6: At most one interval is kept. Any decided bit empties the store. An edge that decides no bit replaces the store with its interval.
- R7: A change on rxLine sampled at rising edge k shows its strobe during the single cycle after rising edge k+2. All strobes are one cycle wide.
- R8: The interval counter saturates. A line that stays still for longer than the counter range still reads as a long interval and gives an abort, with no wrap to a short value.
- R9: An active-low synchronous reset clears the synchroniser, counter, stored interval and all outputs. The first interval after reset is counted from the release of reset.
- R10: bitValid and abortStb are never high together, and bitValue is 0 whenever bitValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Asynchronous demodulated data line |
| bitValid | output | 1 | One-cycle strobe marking a decoded bit |
| bitValue | output | 1 | Decoded bit value, valid with bitValid |
| abortStb | output | 1 | One-cycle strobe on an over-long interval that decides nothing |

## Verification
Each result is due on the third clock after the input toggle is first sampled: two cycles through the synchroniser, then one output register. The bench toggles the line on a falling clock edge and compares the strobes on exactly the third falling edge after that. On every other falling edge until the next toggle, it requires all strobes to be low. Hold times swept from 3 to 60 cycles, both line polarities and the window boundaries are checked against an arithmetic model of the interval rules. A long stuck line and a mid-stream reset are also covered.

// File: rtl/bphase_pkg.sv
package bphase_pkg;

  // Comparison results the datapath hands to the control
  typedef struct packed {
    logic edgeSeen;   // synchronised line changed this cycle
    logic lineLow;    // level after the change is 0
    logic prevValid;  // one interval is held in the store
    logic pairTol;    // stored + current interval in window
    logic halfTol;    // twice the current interval in window
    logic curTol;     // current interval in window
    logic curLong;    // current interval beyond upper limit
    logic prevLong;   // stored interval beyond upper limit
  } measFlags_t;

  // Strobes the control sends back to the interval store
  typedef struct packed {
    logic clearHist;
    logic pushHist;
  } histCtl_t;

endpackage

// File: rtl/bphase_meas.sv
module bphase_meas
  import bphase_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int BIT_RATE    = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  histCtl_t   histCtl,
  output measFlags_t flags
);

  localparam int PERIOD  = CLK_HZ / BIT_RATE;
  localparam int LO_TH   = (3 * PERIOD) / 4;      // strict lower limit
  localparam int HI_TH   = (5 * PERIOD + 3) / 4;  // strict upper limit
  localparam int LONG_TH = (5 * PERIOD) / 4;      // beyond this is long
  localparam int CNT_W   = $clog2(LONG_TH + 2) + 1;
  localparam int SUM_W   = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SUM_W-1:0] LO_V    = SUM_W'(LO_TH);
  localparam logic [SUM_W-1:0] HI_V    = SUM_W'(HI_TH);
  localparam logic [SUM_W-1:0] LONG_V  = SUM_W'(LONG_TH);

  // Synchroniser chain
  logic [SYNC_STAGES-1:0] syncChain;
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= rxLine;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  logic syncLine, lineDly, edgeNow;
  assign syncLine = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) lineDly <= 1'b0;
    else       lineDly <= syncLine;
  end
  assign edgeNow = syncLine ^ lineDly;

  // Saturating interval counter
  logic [CNT_W-1:0] cycCnt, curLen;
  always_ff @(posedge clk) begin
    if (!rstN)                 cycCnt <= '0;
    else if (edgeNow)          cycCnt <= '0;
    else if (cycCnt != CNT_MAX) cycCnt <= cycCnt + 1'b1;
  end
  assign curLen = (cycCnt == CNT_MAX) ? CNT_MAX : cycCnt + 1'b1;

  // Single-entry interval store
  logic [CNT_W-1:0] prevLen;
  logic             prevValid;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLen   <= '0;
      prevValid <= 1'b0;
    end else if (histCtl.clearHist) begin
      prevLen   <= '0;
      prevValid <= 1'b0;
    end else if (histCtl.pushHist) begin
      prevLen   <= curLen;
      prevValid <= 1'b1;
    end
  end

  function automatic logic inWindow(input logic [SUM_W-1:0] len);
    return (len > LO_V) && (len < HI_V);
  endfunction

  logic [SUM_W-1:0] curExt, prevExt, pairSum, dblLen;
  assign curExt  = {1'b0, curLen};
  assign prevExt = {1'b0, prevLen};
  assign pairSum = curExt + prevExt;
  assign dblLen  = {curLen, 1'b0};

  always_comb begin
    flags.edgeSeen  = edgeNow;
    flags.lineLow   = ~syncLine;
    flags.prevValid = prevValid;
    flags.pairTol   = inWindow(pairSum);
    flags.halfTol   = inWindow(dblLen);
    flags.curTol    = inWindow(curExt);
    flags.curLong   = curExt > LONG_V;
    flags.prevLong  = prevExt > LONG_V;
  end

endmodule

// File: rtl/bphase_ctrl.sv
module bphase_ctrl
  import bphase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  measFlags_t flags,
  output histCtl_t   histCtl,
  output logic       bitValid,
  output logic       bitValue,
  output logic       abortStb
);

  logic decOne, decZero, decAbort;

  // Priority: pair sum, first-half recovery, single interval, abort
  always_comb begin
    decOne   = 1'b0;
    decZero  = 1'b0;
    decAbort = 1'b0;
    histCtl  = '0;
    if (flags.edgeSeen) begin
      if (flags.prevValid && flags.pairTol) begin
        decOne = 1'b1;
      end else if (flags.prevValid && flags.lineLow && flags.halfTol &&
                   flags.prevLong) begin
        decOne = 1'b1;
      end else if (flags.curTol) begin
        decZero = 1'b1;
      end else begin
        decAbort = flags.curLong;
      end
      histCtl.clearHist = decOne | decZero;
      histCtl.pushHist  = ~(decOne | decZero);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitValid <= 1'b0;
      bitValue <= 1'b0;
      abortStb <= 1'b0;
    end else begin
      bitValid <= decOne | decZero;
      bitValue <= decOne;
      abortStb <= decAbort;
    end
  end

endmodule

// File: rtl/bphase_bit_decoder.sv
module bphase_bit_decoder
  import bphase_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int BIT_RATE = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxLine,
  output logic bitValid,
  output logic bitValue,
  output logic abortStb
);

  measFlags_t measFlags;
  histCtl_t   histCtl;
  logic       edgeSeen, curLong;

  bphase_meas #(
    .CLK_HZ     (CLK_HZ),
    .BIT_RATE   (BIT_RATE),
    .SYNC_STAGES(2)
  ) u_meas (
    .clk    (clk),
    .rstN   (rstN),
    .rxLine (rxLine),
    .histCtl(histCtl),
    .flags  (measFlags)
  );

  bphase_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .flags   (measFlags),
    .histCtl (histCtl),
    .bitValid(bitValid),
    .bitValue(bitValue),
    .abortStb(abortStb)
  );

  assign edgeSeen = measFlags.edgeSeen;
  assign curLong  = measFlags.curLong;

endmodule

// File: rtl/bphase_bit_decoder_chk.sv
module bphase_bit_decoder_chk (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic bitValue,
  input logic abortStb,
  input logic edgeSeen,
  input logic curLong
);

  // R10: a bit and an abort never coincide
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(bitValid && abortStb));

  // R10: value is quiet without a bit
  p_val_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> !bitValue);

  // R7: strobes last one cycle
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid || abortStb) |=> !(bitValid || abortStb));

  // R7: every strobe follows a detected edge one cycle earlier
  p_from_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid || abortStb) |-> $past(edgeSeen));

  // R5: an abort only follows an over-long interval
  p_abort_long_r5: assert property (@(posedge clk) disable iff (!rstN)
    abortStb |-> $past(curLong));

endmodule

bind bphase_bit_decoder bphase_bit_decoder_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .bitValid(bitValid),
  .bitValue(bitValue),
  .abortStb(abortStb),
  .edgeSeen(edgeSeen),
  .curLong (curLong)
);

// File: tb/test_bphase_bit_decoder.sv
module test_bphase_bit_decoder;

  localparam int CLK_HZ   = 80_000;
  localparam int BIT_RATE = 2000;
  localparam int P        = CLK_HZ / BIT_RATE;  // 40 cycles

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b0;
  logic bitValid, bitValue, abortStb;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // model state
  bit mPrevValid = 1'b0;
  int mPrev      = 0;
  int lastHold   = 1000;

  always #5 clk = ~clk;

  bphase_bit_decoder #(.CLK_HZ(CLK_HZ), .BIT_RATE(BIT_RATE)) i_bphase_bit_decoder (
    .clk     (clk),
    .rstN    (rstN),
    .rxLine  (rxLine),
    .bitValid(bitValid),
    .bitValue(bitValue),
    .abortStb(abortStb)
  );

  function automatic bit inTol(int l);
    return (4 * l > 3 * P) && (4 * l < 5 * P);
  endfunction

  function automatic bit isLong(int l);
    return 4 * l > 5 * P;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {valid,value,abort} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Toggle the line, then hold it for 'hold' cycles.
  task automatic step(int hold);
    int  l = lastHold;
    bit  low;
    logic [2:0] expv;
    string tag;
    bit quietBad = 1'b0;
    rxLine = ~rxLine;
    low = (rxLine == 1'b0);
    if (mPrevValid && inTol(mPrev + l)) begin
      expv = 3'b110; tag = "R2"; mPrevValid = 1'b0;
    end else if (mPrevValid && low && inTol(2 * l) && isLong(mPrev)) begin
      expv = 3'b110; tag = "R4"; mPrevValid = 1'b0;
    end else if (inTol(l)) begin
      expv = 3'b100; tag = "R1/R3"; mPrevValid = 1'b0;
    end else begin
      if (isLong(l)) begin expv = 3'b001; tag = "R5"; end
      else           begin expv = 3'b000; tag = "R6"; end
      mPrev = l; mPrevValid = 1'b1;
    end
    for (int i = 1; i <= hold; i++) begin
      @(negedge clk);
      if (i == 3) check(tag, {bitValid, bitValue, abortStb}, expv);
      else if (bitValid || bitValue || abortStb) quietBad = 1'b1;
    end
    // R7 / R10: nothing outside the due cycle
    check("R7", {quietBad, 2'b00}, 3'b000);
    lastHold = hold;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: outputs quiet in reset
    check("R9", {bitValid, bitValue, abortStb}, 3'b000);
    rstN = 1'b1;
    repeat (80) @(negedge clk);
    check("R9", {bitValid, bitValue, abortStb}, 3'b000);

    // Near-exhaustive sweep of interval pairs after a resync gap
    for (int a = 3; a <= 60; a++) begin
      for (int b = 3; b <= 60; b += 5) begin
        step(70);
        step(a);
        step(b);
      end
    end

    // Clean frames: zeros and ones at nominal timing
    step(P); step(P / 2); step(P / 2); step(P); step(P - 9); step(P + 9);

    // R8: stuck line beyond counter range must still abort
    step(168);
    step(40);
    step(300);
    step(20);
    step(20);
    step(P);

    // R9: reset mid-stream clears store and pipeline
    rxLine = 1'b0;
    rstN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9", {bitValid, bitValue, abortStb}, 3'b000);
    end
    rstN = 1'b1;
    mPrevValid = 1'b0;
    lastHold = 1000;
    repeat (80) @(negedge clk);
    check("R9", {bitValid, bitValue, abortStb}, 3'b000);
    step(20); step(20); step(P); step(10);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule